// File: doc/BRIEF.md
# Stream-to-FIFO Write Bridge

The bridge takes words from an AXI4-Stream source and writes them into a peripheral that exposes a synchronous, multi-thread FIFO write port. The stream's `tdest` picks one of four threads, and the bridge drives that thread number on the port's address lines. The bridge also drives a select line, a write strobe and the data bus. All four port outputs come straight from registers. The first word after an idle gap goes out with select and strobe raised together, so no address-only cycle is spent.

The peripheral reports room through full flags that work as watermarks. There are two flag arrangements, and a parameter picks one. In the shared arrangement, a single flag describes whichever thread is currently addressed, and it only becomes valid a fixed number of clocks after that address is first sampled. In the dedicated arrangement, each thread has its own flag that always describes that thread. The bridge waits out the flag latency on every thread change in shared mode. In dedicated mode it switches threads with no wait. On the same thread it streams one word per clock for as long as the relevant flag stays low.

Top module: `strm_fifo_wr_bridge`

## Requirements
- R1: While `rst_n` is low, `fifo_wr` and `fifo_sel` are 0 and `fifo_addr` is 0.
- R2: When `s_tvalid` and `s_tready` are both 1 at a rising edge, the next cycle shows `fifo_wr`=1 with `fifo_data` equal to that `s_tdata` and `fifo_addr` equal to that `s_tdest`. With no such handshake, the next cycle shows `fifo_wr`=0. Words reach each thread in stream order, and none is lost.
- R3: Words to an unchanged thread are accepted on consecutive clocks, with `s_tready` held at 1, while the relevant flag is 0. In shared mode this also requires that the flag-latency wait is over.
- R4: Shared mode (`DEDICATED`=0). A valid word whose `s_tdest` differs from `fifo_addr` is not accepted. At the next edge `fifo_addr` takes the new thread, with `fifo_sel`=1 and `fifo_wr`=0. `s_tready` then stays 0 for FLAG_LAT-1 cycles after the new address appears, so the peripheral sees the address on FLAG_LAT edges before the first write. After that, `s_tready` follows the flag. With default parameters, the first word to a new thread with room needs FLAG_LAT+1 cycles of `s_tvalid`.
- R5: Shared mode. `fifo_cur_full`=1 forces `s_tready`=0, and no write reaches a thread that has no room.
- R6: Dedicated mode (`DEDICATED`=1). A word to a different thread is accepted in the cycle it is offered if that thread's flag is 0. Its address goes out together with the write.
- R7: Dedicated mode. `s_tready` is 0 exactly when bit `s_tdest` of `fifo_thr_full` is 1. Bit i of `fifo_thr_full` belongs to thread i, and the flags of other threads have no effect.
- R8: In a cycle after an edge with no handshake, `fifo_wr` and `fifo_sel` are 0. The one exception is shared mode, where `fifo_sel` stays 1 during the flag-latency wait. `fifo_wr`=1 always comes with `fifo_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the peripheral port |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tdata | input | DATA_W | Stream data word |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Bridge accepts the word this cycle |
| s_tdest | input | ADDR_W | Target thread of the word |
| fifo_sel | output | 1 | Port select, active high |
| fifo_wr | output | 1 | Write strobe, active high |
| fifo_addr | output | ADDR_W | Thread address |
| fifo_data | output | DATA_W | Write data |
| fifo_cur_full | input | 1 | Shared flag for the addressed thread, 1 = no room |
| fifo_thr_full | input | 2**ADDR_W | Dedicated flags, bit i = thread i has no room |

## Verification
A handshake at one edge shows up on the port one cycle later. The peripheral model then takes that word at the following edge, two edges after acceptance. After a shared-mode address change at edge E, `s_tready` may rise only in the cycle after edge E+FLAG_LAT-1. `s_tready` itself is combinational, so it reacts in the same cycle to a change of flag or `tdest`. The bench keeps to these timings by driving inputs at the falling edge and comparing the registered outputs there. It compares `s_tready` 1 ns later, and it updates its queue-based model and its peripheral 1 ns after the rising edge. Each cycle's expectation therefore comes from the previous edge's handshake and the cycle count since the last address change.

// File: rtl/swb_pkg.sv
package swb_pkg;
    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } swb_state_e;
endpackage

// File: rtl/swb_room_sel.sv
// Decides whether the offered word may be written this cycle, given the flag
// arrangement chosen by DEDICATED.
module swb_room_sel #(
    parameter int ADDR_W    = 2,
    parameter bit DEDICATED = 1'b0,
    localparam int NUM_THR  = 1 << ADDR_W
) (
    input  logic               cur_full,
    input  logic [NUM_THR-1:0] thr_full,
    input  logic [ADDR_W-1:0]  tgt,
    input  logic [ADDR_W-1:0]  cur_addr,
    output logic               may_write
);
    generate
        if (DEDICATED) begin : g_ded
            // each thread's flag is always valid: only the target's matters
            logic unused_ded;
            assign unused_ded = ^{cur_full, cur_addr};
            assign may_write  = !thr_full[tgt];
        end else begin : g_shared
            // the shared flag describes the addressed thread only
            logic unused_shr;
            assign unused_shr = ^thr_full;
            assign may_write  = !cur_full && (tgt == cur_addr);
        end
    endgenerate
endmodule

// File: rtl/swb_settle_ctr.sv
// Counts the cycles after an address change until the shared flag is valid.
module swb_settle_ctr #(
    parameter int FLAG_LAT  = 3,
    parameter bit INIT_BUSY = 1'b1,
    localparam int CW       = $clog2(FLAG_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam logic [CW-1:0] LOAD_V = CW'(FLAG_LAT - 1);
    localparam logic [CW-1:0] RST_V  = INIT_BUSY ? LOAD_V : '0;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD_V;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_V;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // last waiting cycle: the state leaves the wait on this edge
    assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/strm_fifo_wr_bridge.sv
// Stream to synchronous multi-thread FIFO write bridge. FLAG_LAT must be >= 2.
module strm_fifo_wr_bridge
    import swb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int FLAG_LAT  = 3,
    parameter bit DEDICATED = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        s_tdata,
    input  logic                     s_tvalid,
    output logic                     s_tready,
    input  logic [ADDR_W-1:0]        s_tdest,
    output logic                     fifo_sel,
    output logic                     fifo_wr,
    output logic [ADDR_W-1:0]        fifo_addr,
    output logic [DATA_W-1:0]        fifo_data,
    input  logic                     fifo_cur_full,
    input  logic [(1<<ADDR_W)-1:0]   fifo_thr_full
);
    localparam int NUM_THR = 1 << ADDR_W;

    typedef struct packed {
        swb_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr;
        logic              sel;
    } regs_t;

    // shared mode starts with a wait: the flag for thread 0 is not yet valid
    localparam regs_t RST_VAL = '{
        state: (DEDICATED ? ST_RUN : ST_SETTLE),
        addr:  '0,
        data:  '0,
        wr:    1'b0,
        sel:   1'b0
    };

    regs_t r_d, r_q;
    logic  may_write;
    logic  settle_done;
    logic  switch_go;
    logic  xfer;

    swb_room_sel #(
        .ADDR_W    (ADDR_W),
        .DEDICATED (DEDICATED)
    ) u_room (
        .cur_full  (fifo_cur_full),
        .thr_full  (fifo_thr_full),
        .tgt       (s_tdest),
        .cur_addr  (r_q.addr),
        .may_write (may_write)
    );

    swb_settle_ctr #(
        .FLAG_LAT  (FLAG_LAT),
        .INIT_BUSY (!DEDICATED)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (switch_go),
        .expire (settle_done)
    );

    assign s_tready = (r_q.state == ST_RUN) && may_write;
    assign xfer     = s_tvalid && s_tready;

    // a thread change with the shared flag needs a fresh address and a wait
    assign switch_go = !DEDICATED && (r_q.state == ST_RUN) && s_tvalid &&
                       (s_tdest != r_q.addr);

    always_comb begin
        r_d     = r_q;
        r_d.wr  = xfer;
        r_d.sel = xfer;
        if (xfer) begin
            r_d.data = s_tdata;
            r_d.addr = s_tdest;
        end
        unique case (r_q.state)
            ST_RUN: begin
                if (switch_go) begin
                    r_d.state = ST_SETTLE;
                    r_d.addr  = s_tdest;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    r_d.state = ST_RUN;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
        // keep the port selected while its flag pipeline fills
        if (r_d.state == ST_SETTLE) begin
            r_d.sel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign fifo_sel  = r_q.sel;
    assign fifo_wr   = r_q.wr;
    assign fifo_addr = r_q.addr;
    assign fifo_data = r_q.data;

    logic unused_thr;
    assign unused_thr = (NUM_THR == 0);
endmodule

// File: rtl/strm_fifo_wr_bridge_chk.sv
module strm_fifo_wr_bridge_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter bit DEDICATED = 1'b0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [DATA_W-1:0]      s_tdata,
    input logic                   s_tvalid,
    input logic                   s_tready,
    input logic [ADDR_W-1:0]      s_tdest,
    input logic                   fifo_sel,
    input logic                   fifo_wr,
    input logic [ADDR_W-1:0]      fifo_addr,
    input logic [DATA_W-1:0]      fifo_data,
    input logic                   fifo_cur_full,
    input logic [(1<<ADDR_W)-1:0] fifo_thr_full
);
    // R2
    hs_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready) |=> (fifo_wr && fifo_data == $past(s_tdata) &&
                                    fifo_addr == $past(s_tdest)));

    // R2
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tvalid && s_tready) |=> !fifo_wr);

    // R8
    wr_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> fifo_sel);

    // R5
    shared_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!DEDICATED && fifo_cur_full) |-> !s_tready);

    // R7
    ded_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEDICATED && fifo_thr_full[s_tdest]) |-> !s_tready);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!DEDICATED && fifo_addr != $past(fifo_addr)) |->
            (!s_tready && fifo_sel && !fifo_wr));
endmodule

bind strm_fifo_wr_bridge strm_fifo_wr_bridge_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .DEDICATED (DEDICATED)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_tdata       (s_tdata),
    .s_tvalid      (s_tvalid),
    .s_tready      (s_tready),
    .s_tdest       (s_tdest),
    .fifo_sel      (fifo_sel),
    .fifo_wr       (fifo_wr),
    .fifo_addr     (fifo_addr),
    .fifo_data     (fifo_data),
    .fifo_cur_full (fifo_cur_full),
    .fifo_thr_full (fifo_thr_full)
);

// File: tb/strm_fifo_wr_bridge_hx.sv
// One bridge instance, its stimulus, a peripheral model and a reference model.
module strm_fifo_wr_bridge_hx #(
    parameter bit DED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_err,
    output logic done
);
    localparam int DW = 16, AW = 2, NT = 4, LAT = 3, DEPTH = 8, WM = 4;

    logic [DW-1:0] tdata;
    logic          tvalid, tready;
    logic [AW-1:0] tdest;
    logic          sel, wr;
    logic [AW-1:0] faddr;
    logic [DW-1:0] fdata;
    logic          flag_sh;
    logic [NT-1:0] flag_ded;

    strm_fifo_wr_bridge #(
        .DATA_W (DW), .ADDR_W (AW), .FLAG_LAT (LAT), .DEDICATED (DED)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .s_tdata (tdata), .s_tvalid (tvalid), .s_tready (tready), .s_tdest (tdest),
        .fifo_sel (sel), .fifo_wr (wr), .fifo_addr (faddr), .fifo_data (fdata),
        .fifo_cur_full (flag_sh), .fifo_thr_full (flag_ded)
    );

    int            fill [NT];
    logic [DW-1:0] sent [NT][$];
    int            cyc, settle_until, age, word_id;
    logic          exp_wr, exp_sel, last_hs;
    logic [AW-1:0] exp_addr, a_s1, last_a;
    logic [DW-1:0] exp_data;
    logic [NT-1:0] drain_en;
    logic          drv_valid;
    logic [AW-1:0] drv_dest;
    logic [DW-1:0] drv_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s (mode %0d): actual %0h expected %0h", req, what, DED, act, expv);
        end
    endtask

    task automatic step();
        logic          p_wr, hs, er, sw;
        logic [AW-1:0] p_addr;
        logic [DW-1:0] p_data, e;
        string         rq;
        int            c_old;
        @(negedge clk);
        chk(wr === exp_wr, "R2", "strobe", wr, exp_wr);
        if (exp_wr) chk(fdata === exp_data, "R2", "data", fdata, exp_data);
        chk(faddr === exp_addr, DED ? "R6" : "R4", "address", faddr, exp_addr);
        chk(sel === exp_sel, "R8", "select", sel, exp_sel);
        p_wr = wr; p_addr = faddr; p_data = fdata;
        tvalid = drv_valid; tdest = drv_dest; tdata = drv_data;
        #1;
        if (DED) begin
            er = (cyc >= settle_until) && !flag_ded[tdest];
            rq = flag_ded[tdest] ? "R7" : "R3";
        end else begin
            er = (cyc >= settle_until) && (tdest == exp_addr) && !flag_sh;
            rq = (cyc < settle_until) ? "R4" : (flag_sh ? "R5" : "R3");
        end
        chk(tready === er, rq, "tready", tready, er);
        hs = tvalid && tready;
        last_hs = hs;
        c_old = cyc;
        @(posedge clk);
        #1;
        cyc++;
        // peripheral samples the port at this edge
        if (p_addr != last_a) age = 0; else age++;
        last_a = p_addr;
        if (p_wr) begin
            chk(fill[p_addr] < DEPTH, "R5", "room at write", fill[p_addr], DEPTH);
            if (!DED) chk(age >= LAT, "R4", "address age at write", age, LAT);
            if (sent[p_addr].size() == 0) begin
                chk(1'b0, "R2", "unexpected write", p_data, 0);
            end else begin
                e = sent[p_addr].pop_front();
                chk(p_data == e, "R2", "thread order", p_data, e);
            end
            fill[p_addr]++;
        end
        for (int t = 0; t < NT; t++) if (drain_en[t] && fill[t] > 0) fill[t]--;
        flag_sh = (fill[a_s1] >= WM);
        a_s1 = p_addr;
        for (int t = 0; t < NT; t++) flag_ded[t] = (fill[t] >= WM);
        // reference for the next cycle
        sw = !DED && tvalid && (c_old >= settle_until) && (tdest != exp_addr);
        exp_wr = hs; exp_sel = hs;
        if (hs) begin
            exp_data = tdata; exp_addr = tdest;
            sent[tdest].push_back(tdata);
        end
        if (sw) begin
            exp_addr = tdest;
            settle_until = cyc + LAT - 1;
        end
        if (cyc < settle_until) exp_sel = 1'b1;
    endtask

    task automatic send_word(input int t, output int nst);
        drv_valid = 1'b1; drv_dest = AW'(t); drv_data = DW'({t[1:0], 14'(word_id)});
        word_id++;
        nst = 0;
        do begin
            step();
            nst++;
            if (nst > 20) drain_en = '1;
        end while (!last_hs && nst < 200);
        drv_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    initial begin
        int  n, k;
        bit  stalled;
        int  seq [4] = '{1, 2, 3, 0};
        n_chk = 0; n_err = 0; done = 1'b0;
        tvalid = 1'b0; tdest = '0; tdata = '0;
        drv_valid = 1'b0; drv_dest = '0; drv_data = '0;
        flag_sh = 1'b0; flag_ded = '0;
        for (int t = 0; t < NT; t++) fill[t] = 0;
        exp_wr = 1'b0; exp_sel = 1'b0; exp_addr = '0; exp_data = '0;
        a_s1 = '0; last_a = '0; age = 0; word_id = 0; last_hs = 1'b0;
        drain_en = '1;
        @(negedge clk);
        // R1: outputs held in reset
        chk(wr === 1'b0, "R1", "strobe in reset", wr, 0);
        chk(sel === 1'b0, "R1", "select in reset", sel, 0);
        chk(faddr === '0, "R1", "address in reset", faddr, 0);
        wait (rst_n === 1'b1);
        cyc = 0;
        settle_until = DED ? 0 : LAT - 1;

        // R3: burst to one thread
        send_word(0, n);
        for (int i = 1; i < 12; i++) begin
            send_word(0, n);
            chk(n == 1, "R3", "back-to-back cycles", n, 1);
        end
        idle(3);

        // R4 / R6: thread changes
        foreach (seq[j]) begin
            send_word(seq[j], n);
            if (DED) chk(n == 1, "R6", "switch cycles", n, 1);
            else     chk(n == LAT + 1, "R4", "switch cycles", n, LAT + 1);
            for (int i = 0; i < 2; i++) begin
                send_word(seq[j], n);
                chk(n == 1, "R3", "after switch", n, 1);
            end
        end

        // R8: words with gaps
        for (int i = 0; i < 6; i++) begin
            send_word(2, n);
            idle(1 + (i % 2));
        end

        // R5: thread 1 stops draining, stream must stall
        drain_en[1] = 1'b0;
        stalled = 1'b0;
        for (int i = 0; i < 12; i++) begin
            send_word(1, n);
            if (i > 0 && n > 1) stalled = 1'b1;
        end
        chk(stalled, "R5", "stall on full flag", stalled, 1);
        drain_en = '1;
        idle(6);

        // R7: one thread full, another thread still accepted
        drain_en[1] = 1'b0;
        k = 0;
        while (!(DED ? flag_ded[1] : flag_sh) && k < 30) begin
            send_word(1, n);
            k++;
        end
        send_word(3, n);
        if (DED) chk(n == 1, "R7", "other thread unaffected", n, 1);
        else     chk(n == LAT + 1, "R4", "switch away from full thread", n, LAT + 1);
        drain_en = '1;
        idle(12);

        for (int t = 0; t < NT; t++)
            chk(sent[t].size() == 0, "R2", "words delivered", sent[t].size(), 0);
        done = 1'b1;
    end
endmodule

// File: tb/strm_fifo_wr_bridge_tb.sv
module strm_fifo_wr_bridge_tb;
    logic clk = 1'b0;
    logic rst_n;
    int   chk_s, err_s, chk_d, err_d;
    logic done_s, done_d;

    always #10 clk = ~clk;

    strm_fifo_wr_bridge_hx #(.DED(1'b0)) u_shared (
        .clk (clk), .rst_n (rst_n), .n_chk (chk_s), .n_err (err_s), .done (done_s)
    );
    strm_fifo_wr_bridge_hx #(.DED(1'b1)) u_dedic (
        .clk (clk), .rst_n (rst_n), .n_chk (chk_d), .n_err (err_d), .done (done_d)
    );

    initial begin
        int wd = 0;
        int extra = 0;
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #5 rst_n = 1'b1;
        while (!(done_s === 1'b1 && done_d === 1'b1) && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (wd >= 100000) begin
            extra = 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
        end
        $display("Simulation finished: %0d checks, %0d errors",
                 chk_s + chk_d + extra, err_s + err_d + extra);
        $finish;
    end
endmodule